// File: doc/BRIEF.md
# Receive Ring Frame Writer

This block stores incoming network frames into a circular region of an 8 KB byte-addressed RAM. The region is bounded by two programmable addresses. A receive path delivers each frame as a start strobe, a run of byte strobes and an end strobe that carries a 32-bit status word. The block streams the bytes into the ring, leaving six bytes free at the frame's base. Once the frame is complete, it fills those six bytes with a header: a link to the start of the following frame, then a status vector.

The block never stores into the byte the host's read pointer addresses. A frame that would need that byte is abandoned and flagged, and its space is reused by the next frame. Every following frame starts on an even address. A saturating count of the frames the host has not yet consumed drives a pending flag, and the host lowers the count with a decrement strobe.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset, pkt_count is 0, pkt_pending, mem_we and rx_err are low, and wr_ptr equals cfg_start until the first frame is committed.
- R2: The data bytes of a frame are written one per accepted byte, in order, starting 6 addresses past the frame base. Every address that passes cfg_end continues at cfg_start, and no write ever lands outside [cfg_start, cfg_end].
- R3: The header occupies the 6 ring positions starting at the frame base, in this order: link bits 7:0, link bits 15:8 (upper 3 bits zero), then status bits 7:0, 15:8, 23:16 and 31:24. Header positions wrap like data.
- R4: The link equals the address that follows the last data byte, advanced by one more ring position when that address is odd. It is therefore always even, given an even cfg_start.
- R5: The stored status takes bits 30:16 from rx_status as sampled with rx_eof. Bit 31 is forced to 0, and bits 15:0 hold the number of data bytes.
- R6: The space is the ring distance from the frame base to host_rdptr. A frame commits only if 6 plus its byte count, rounded up to even, does not exceed that space. Otherwise it is aborted: either at the first data byte whose offset reaches the space, or at rx_eof. On abort, rx_err pulses for one cycle, no header is written, the remaining bytes are dropped, and wr_ptr and pkt_count keep their values. No write ever targets host_rdptr.
- R7: Each committed frame raises pkt_count by one, and the count holds at 255 instead of wrapping.
- R8: host_dec lowers a nonzero pkt_count by one and leaves 0 unchanged. host_dec in the same cycle as a commit leaves the count unchanged. pkt_pending is high exactly when pkt_count is nonzero.
- R9: rx_valid and rx_eof outside a frame, and rx_valid in the same cycle as rx_eof, write nothing and raise no error.
- R10: wr_ptr moves to the link value in the cycle the last header byte is written, and changes at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_start | input | 13 | First address of the ring (even) |
| cfg_end | input | 13 | Last address of the ring |
| host_rdptr | input | 13 | Host read pointer; the block writes up to but not into this byte |
| rx_sof | input | 1 | Frame start strobe (no data) |
| rx_valid | input | 1 | Data byte strobe |
| rx_data | input | 8 | Data byte |
| rx_eof | input | 1 | Frame end strobe (no data) |
| rx_status | input | 32 | Frame status, sampled with rx_eof |
| host_dec | input | 1 | Frame consumed strobe |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | 13 | RAM write address |
| mem_wdata | output | 8 | RAM write data |
| pkt_count | output | 8 | Count of unconsumed frames |
| pkt_pending | output | 1 | High while pkt_count is nonzero |
| rx_err | output | 1 | One-cycle pulse when a frame is abandoned |
| wr_ptr | output | 13 | Base address of the next frame |

## Verification
A wrong byte offset inside the controller shows up on the write port one cycle after the offending byte strobe, as a misplaced or missing data byte. A wrong space computation shows up as a missing or spurious rx_err pulse, or as a write count that differs from the one predicted from the ring distance. A wrong link or status latch shows up only when the header is read back six to seven cycles after rx_eof, and again as a wrong wr_ptr at the start of the next frame. Counter faults show up at the boundaries: at 255, at 0, and when a decrement coincides with a commit.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  localparam int AW        = 13;
  localparam int HDR_BYTES = 6;
  localparam int STAT_W    = 32;
  localparam int BCNT_W    = 16;

  typedef logic [AW-1:0] addr_t;
  typedef logic [AW:0]   span_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DATA,
    ST_DROP,
    ST_HDR
  } rxb_state_e;

  // number of bytes in the ring [lo, hi]
  function automatic span_t ring_size(addr_t lo, addr_t hi);
    return span_t'(hi) - span_t'(lo) + span_t'(1);
  endfunction

  // advance a by n positions inside the ring, wrapping at hi
  function automatic addr_t ring_add(addr_t a, span_t n, addr_t lo, addr_t hi);
    span_t sz;
    span_t o;
    sz = ring_size(lo, hi);
    o  = span_t'(a) - span_t'(lo) + n;
    if (o >= sz) o = o - sz;
    return lo + addr_t'(o);
  endfunction

  // positions from 'from' up to (not including) 'to', walking forward
  function automatic span_t ring_gap(addr_t from, addr_t to, addr_t lo, addr_t hi);
    span_t sz;
    span_t of;
    span_t ot;
    sz = ring_size(lo, hi);
    of = span_t'(from) - span_t'(lo);
    ot = span_t'(to) - span_t'(lo);
    if (ot >= of) return ot - of;
    return ot + sz - of;
  endfunction

  // round an offset up to the next even value
  function automatic span_t even_up(span_t v);
    return v + span_t'(v[0]);
  endfunction
endpackage

// File: rtl/rxb_space_guard.sv
module rxb_space_guard
  import rxb_pkg::*;
(
  input  addr_t cfg_start,
  input  addr_t cfg_end,
  input  addr_t host_rdptr,
  input  addr_t base_i,
  input  span_t off_i,
  output span_t space_o,
  output logic  data_fit_o,
  output logic  close_fit_o
);
  span_t space_w;
  span_t need_w;

  always_comb begin
    space_w     = ring_gap(base_i, host_rdptr, cfg_start, cfg_end);
    need_w      = even_up(off_i);
    data_fit_o  = off_i < space_w;
    close_fit_o = need_w <= space_w;
    space_o     = space_w;
  end
endmodule

// File: rtl/rxb_pkt_counter.sv
module rxb_pkt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pending_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             at_max;
  logic             at_zero;

  assign at_max  = cnt_q == CNT_MAX;
  assign at_zero = cnt_q == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (inc_i && !dec_i) begin
      if (!at_max) cnt_q <= cnt_q + 1'b1;
    end else if (dec_i && !inc_i) begin
      if (!at_zero) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o     = cnt_q;
  assign pending_o = !at_zero;

  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_o == CNT_MAX && !dec_i) |=> cnt_o == CNT_MAX); // R7
  AST_CNT_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !inc_i && cnt_o != '0) |=> cnt_o == CNT_W'($past(cnt_o) - 1'b1)); // R8
  AST_CNT_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && inc_i) |=> $stable(cnt_o)); // R8
endmodule

// File: rtl/rxb_frame_ctrl.sv
module rxb_frame_ctrl
  import rxb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  addr_t       cfg_start,
  input  addr_t       cfg_end,
  input  addr_t       host_rdptr,
  input  logic        rx_sof,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_eof,
  input  logic [STAT_W-1:0] rx_status,
  input  logic        data_fit_i,
  input  logic        close_fit_i,
  output addr_t       base_o,
  output span_t       off_o,
  output logic        commit_o,
  output logic        mem_we,
  output addr_t       mem_addr,
  output logic [7:0]  mem_wdata,
  output logic        rx_err
);
  localparam int    LINK_PAD = BCNT_W - AW;
  localparam span_t HDR_SPAN = span_t'(HDR_BYTES);
  localparam logic [2:0] HDR_LAST = 3'(HDR_BYTES - 1);

  rxb_state_e   state_q;
  logic         have_ptr_q;
  addr_t        wr_q;
  addr_t        data_addr_q;
  span_t        off_q;
  addr_t        link_q;
  logic [STAT_W-1:0] stat_q;
  logic [2:0]   hidx_q;
  logic         we_q;
  addr_t        addr_q;
  logic [7:0]   wdata_q;
  logic         err_q;

  // named events for checking
  addr_t        base_w;
  logic         byte_take;
  logic         byte_abort;
  logic         close_ok;
  logic         close_abort;
  logic         abort_evt;
  logic         commit_evt;
  addr_t        link_w;
  logic [BCNT_W-1:0] bcnt_w;
  logic [BCNT_W-1:0] link16;
  logic [7:0]   hdr_byte;
  addr_t        hdr_addr;

  assign base_w      = have_ptr_q ? wr_q : cfg_start;
  assign byte_take   = (state_q == ST_DATA) && !rx_eof && rx_valid && data_fit_i;
  assign byte_abort  = (state_q == ST_DATA) && !rx_eof && rx_valid && !data_fit_i;
  assign close_ok    = (state_q == ST_DATA) && rx_eof && close_fit_i;
  assign close_abort = (state_q == ST_DATA) && rx_eof && !close_fit_i;
  assign abort_evt   = byte_abort || close_abort;
  assign commit_evt  = (state_q == ST_HDR) && (hidx_q == HDR_LAST);

  always_comb begin
    link_w   = data_addr_q[0] ? ring_add(data_addr_q, span_t'(1), cfg_start, cfg_end)
                              : data_addr_q;
    bcnt_w   = BCNT_W'({{(BCNT_W-AW-1){1'b0}}, off_q} - BCNT_W'(HDR_BYTES));
    link16   = {{LINK_PAD{1'b0}}, link_q};
    hdr_addr = ring_add(base_w, span_t'(hidx_q), cfg_start, cfg_end);
    case (hidx_q)
      3'd0:    hdr_byte = link16[7:0];
      3'd1:    hdr_byte = link16[15:8];
      3'd2:    hdr_byte = stat_q[7:0];
      3'd3:    hdr_byte = stat_q[15:8];
      3'd4:    hdr_byte = stat_q[23:16];
      default: hdr_byte = stat_q[31:24];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      have_ptr_q  <= 1'b0;
      wr_q        <= '0;
      data_addr_q <= '0;
      off_q       <= '0;
      link_q      <= '0;
      stat_q      <= '0;
      hidx_q      <= '0;
      we_q        <= 1'b0;
      addr_q      <= '0;
      wdata_q     <= '0;
      err_q       <= 1'b0;
    end else begin
      we_q  <= 1'b0;
      err_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (rx_sof) begin
            data_addr_q <= ring_add(base_w, HDR_SPAN, cfg_start, cfg_end);
            off_q       <= HDR_SPAN;
            state_q     <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (close_ok) begin
            link_q  <= link_w;
            stat_q  <= {1'b0, rx_status[30:16], bcnt_w};
            hidx_q  <= '0;
            state_q <= ST_HDR;
          end else if (close_abort) begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else if (byte_take) begin
            we_q        <= 1'b1;
            addr_q      <= data_addr_q;
            wdata_q     <= rx_data;
            data_addr_q <= ring_add(data_addr_q, span_t'(1), cfg_start, cfg_end);
            off_q       <= off_q + span_t'(1);
          end else if (byte_abort) begin
            err_q   <= 1'b1;
            state_q <= ST_DROP;
          end
        end
        ST_DROP: begin
          if (rx_eof) state_q <= ST_IDLE;
        end
        default: begin
          we_q    <= 1'b1;
          addr_q  <= hdr_addr;
          wdata_q <= hdr_byte;
          hidx_q  <= hidx_q + 3'd1;
          if (commit_evt) begin
            wr_q       <= link_q;
            have_ptr_q <= 1'b1;
            state_q    <= ST_IDLE;
          end
        end
      endcase
    end
  end

  assign base_o    = base_w;
  assign off_o     = off_q;
  assign commit_o  = commit_evt;
  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign rx_err    = err_q;

  AST_NO_RDPTR_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr != $past(host_rdptr)); // R6
  AST_ADDR_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr >= cfg_start && mem_addr <= cfg_end)); // R2
  AST_LINK_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_evt && !cfg_start[0]) |=> !base_o[0]); // R4
  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (!mem_we && rx_err)); // R6
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |=> !rx_err); // R6
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (have_ptr_q && !commit_evt) |=> $stable(base_o)); // R10
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE || state_q == ST_DROP) |=> !mem_we); // R9
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
  parameter int CNT_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [12:0] cfg_start,
  input  logic [12:0] cfg_end,
  input  logic [12:0] host_rdptr,
  input  logic        rx_sof,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_eof,
  input  logic [31:0] rx_status,
  input  logic        host_dec,
  output logic        mem_we,
  output logic [12:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic [CNT_W-1:0] pkt_count,
  output logic        pkt_pending,
  output logic        rx_err,
  output logic [12:0] wr_ptr
);
  import rxb_pkg::*;

  addr_t base_w;
  span_t off_w;
  span_t space_w;
  logic  data_fit_w;
  logic  close_fit_w;
  logic  commit_w;

  rxb_space_guard u_guard (
    .cfg_start  (cfg_start),
    .cfg_end    (cfg_end),
    .host_rdptr (host_rdptr),
    .base_i     (base_w),
    .off_i      (off_w),
    .space_o    (space_w),
    .data_fit_o (data_fit_w),
    .close_fit_o(close_fit_w)
  );

  rxb_frame_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_start  (cfg_start),
    .cfg_end    (cfg_end),
    .host_rdptr (host_rdptr),
    .rx_sof     (rx_sof),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .rx_eof     (rx_eof),
    .rx_status  (rx_status),
    .data_fit_i (data_fit_w),
    .close_fit_i(close_fit_w),
    .base_o     (base_w),
    .off_o      (off_w),
    .commit_o   (commit_w),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .rx_err     (rx_err)
  );

  rxb_pkt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc_i    (commit_w),
    .dec_i    (host_dec),
    .cnt_o    (pkt_count),
    .pending_o(pkt_pending)
  );

  assign wr_ptr = base_w;

  AST_COMMIT_NEEDS_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_w |-> space_w >= span_t'(HDR_BYTES)); // R6
endmodule

// File: tb/tb_rx_ring_writer.sv
module tb_rx_ring_writer;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] cfg_start = '0;
  logic [12:0] cfg_end = 13'd31;
  logic [12:0] host_rdptr = 13'd31;
  logic        rx_sof = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_eof = 1'b0;
  logic [31:0] rx_status = '0;
  logic        host_dec = 1'b0;
  logic        mem_we;
  logic [12:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  pkt_count;
  logic        pkt_pending;
  logic        rx_err;
  logic [12:0] wr_ptr;

  rx_ring_writer dut (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_end(cfg_end),
    .host_rdptr(host_rdptr), .rx_sof(rx_sof), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_eof(rx_eof), .rx_status(rx_status),
    .host_dec(host_dec), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .pkt_count(pkt_count), .pkt_pending(pkt_pending),
    .rx_err(rx_err), .wr_ptr(wr_ptr)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  int rs = 0;
  int size = 32;
  int exp_cnt = 0;
  logic [7:0] shadow [0:63];
  int wr_seen = 0;
  int err_seen = 0;
  int out_ring = 0;
  int rd_hits = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int radd(int a, int n);
    return rs + ((a - rs + n) % size);
  endfunction

  function automatic int gap(int from, int to);
    return ((to - rs) - (from - rs) + size) % size;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we) begin
        wr_seen++;
        if (int'(mem_addr) >= rs && int'(mem_addr) < rs + size)
          shadow[int'(mem_addr) - rs] = mem_wdata;
        else
          out_ring++;
        if (mem_addr == host_rdptr) rd_hits++;
      end
      if (rx_err) err_seen++;
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic set_ring(int lo, int sz);
    rs = lo;
    size = sz;
    cfg_start = 13'(lo);
    cfg_end = 13'(lo + sz - 1);
    for (int i = 0; i < 64; i++) shadow[i] = 8'h00;
  endtask

  task automatic pop();
    host_dec = 1'b1;
    tick();
    host_dec = 1'b0;
    if (exp_cnt > 0) exp_cnt--;
  endtask

  // sends one frame and checks the stored result against the model
  task automatic run_frame(int len, logic [31:0] st, bit dec_at_commit, int seed, bit full);
    int wr0, free, need, nexp, bad, link;
    logic [31:0] sexp, sgot;
    wr0 = int'(wr_ptr);
    free = gap(wr0, int'(host_rdptr));
    need = 6 + len;
    need = need + (need & 1);
    wr_seen = 0;
    err_seen = 0;
    rx_sof = 1'b1; tick(); rx_sof = 1'b0;
    for (int i = 0; i < len; i++) begin
      rx_valid = 1'b1;
      rx_data = 8'((i * 7 + seed) & 8'hFF);
      tick();
    end
    rx_valid = 1'b0;
    rx_eof = 1'b1;
    rx_status = st;
    tick();
    rx_eof = 1'b0;
    if (dec_at_commit) begin
      repeat (5) tick();
      host_dec = 1'b1;
      tick();
      host_dec = 1'b0;
      tick();
    end else begin
      repeat (7) tick();
    end
    if (need <= free) begin
      chk(err_seen == 0, "R6 no error on fitting frame", err_seen, 0);
      chk(wr_seen == len + 6, "R2 write count", wr_seen, len + 6);
      link = radd(wr0, need);
      chk(int'(wr_ptr) == link, "R10 wr_ptr moves to link", wr_ptr, link);
      if (!dec_at_commit) exp_cnt = (exp_cnt < 255) ? exp_cnt + 1 : 255;
      chk(int'(pkt_count) == exp_cnt, "R7 count after commit", pkt_count, exp_cnt);
      chk(pkt_pending == (exp_cnt != 0), "R8 pending follows count", pkt_pending, exp_cnt != 0);
      if (full) begin
        chk(shadow[radd(wr0, 0) - rs] == 8'(link) &&
            shadow[radd(wr0, 1) - rs] == 8'(link >> 8),
            "R3 R4 header link bytes",
            {shadow[radd(wr0, 1) - rs], shadow[radd(wr0, 0) - rs]}, link);
        chk(link % 2 == 0, "R4 link even", link, link + (link & 1));
        sexp = {1'b0, st[30:16], 16'(len)};
        sgot = {shadow[radd(wr0, 5) - rs], shadow[radd(wr0, 4) - rs],
                shadow[radd(wr0, 3) - rs], shadow[radd(wr0, 2) - rs]};
        chk(sgot == sexp, "R3 R5 header status bytes", sgot, sexp);
        bad = 0;
        for (int i = 0; i < len; i++)
          if (shadow[radd(wr0, 6 + i) - rs] != 8'((i * 7 + seed) & 8'hFF)) bad++;
        chk(bad == 0, "R2 data bytes in order with wrap", bad, 0);
      end
    end else begin
      nexp = free - 6;
      if (nexp < 0) nexp = 0;
      if (nexp > len) nexp = len;
      chk(err_seen == 1, "R6 error pulse on abort", err_seen, 1);
      chk(wr_seen == nexp, "R6 bytes before abort, no header", wr_seen, nexp);
      chk(int'(wr_ptr) == wr0, "R6 wr_ptr rolled back", wr_ptr, wr0);
      chk(int'(pkt_count) == exp_cnt, "R6 count unchanged on abort", pkt_count, exp_cnt);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    set_ring(0, 32);
    do_reset();
    // R1 reset state
    chk(pkt_count == 0, "R1 count after reset", pkt_count, 0);
    chk(!pkt_pending, "R1 pending after reset", pkt_pending, 0);
    chk(!mem_we && !rx_err, "R1 no write or error after reset", {mem_we, rx_err}, 0);

    set_ring(13'h1FC0, 64);
    #1;
    chk(int'(wr_ptr) == rs, "R1 wr_ptr follows cfg_start", wr_ptr, rs);

    // R9 stray strobes outside a frame
    wr_seen = 0; err_seen = 0;
    for (int i = 0; i < 4; i++) begin
      rx_valid = 1'b1; rx_data = 8'(i); tick();
    end
    rx_valid = 1'b0;
    rx_eof = 1'b1; tick(); rx_eof = 1'b0;
    repeat (3) tick();
    chk(wr_seen == 0 && err_seen == 0, "R9 strobes outside frame ignored", wr_seen + err_seen, 0);
    chk(int'(wr_ptr) == rs, "R9 wr_ptr untouched by strobes", wr_ptr, rs);

    // R9 byte together with eof is not stored
    host_rdptr = 13'(radd(int'(wr_ptr), size - 1));
    wr_seen = 0;
    rx_sof = 1'b1; tick(); rx_sof = 1'b0;
    rx_eof = 1'b1; rx_valid = 1'b1; rx_status = 32'h0; tick();
    rx_eof = 1'b0; rx_valid = 1'b0;
    repeat (7) tick();
    chk(wr_seen == 6, "R9 byte with eof dropped", wr_seen, 6);
    exp_cnt = 1;
    pop();
    chk(pkt_count == 0, "R8 decrement to zero", pkt_count, 0);

    // sweep of lengths with a drained ring: wraps, padding, eof abort at 57+
    for (int len = 0; len <= 60; len++) begin
      host_rdptr = 13'(radd(int'(wr_ptr), size - 1));
      run_frame(len, {1'b1, 7'(len * 3), 8'hC3, 16'hBEEF}, 1'b0, len, 1'b1);
      if (exp_cnt > 0) pop();
    end
    chk(pkt_count == 0 && !pkt_pending, "R8 drained after sweep", pkt_count, 0);

    // held read pointer: ring fills until a frame is abandoned
    host_rdptr = 13'(radd(int'(wr_ptr), size - 1));
    run_frame(10, 32'h8012_3456, 1'b0, 3, 1'b1);
    run_frame(10, 32'h0045_0000, 1'b0, 4, 1'b1);
    run_frame(10, 32'h7FFF_FFFF, 1'b0, 5, 1'b1);
    run_frame(10, 32'h0000_0000, 1'b0, 6, 1'b1);
    run_frame(9,  32'h0011_0000, 1'b0, 7, 1'b1);
    run_frame(8,  32'h0022_0000, 1'b0, 8, 1'b1);
    run_frame(0,  32'h0033_0000, 1'b0, 9, 1'b1);
    chk(rd_hits == 0, "R6 no write at read pointer", rd_hits, 0);
    chk(out_ring == 0, "R2 writes stay inside ring", out_ring, 0);

    // saturation of the frame count
    set_ring(0, 32);
    do_reset();
    exp_cnt = 0;
    for (int k = 0; k < 257; k++) begin
      host_rdptr = 13'(radd(int'(wr_ptr), size - 1));
      run_frame(k % 3, 32'h0001_0000, 1'b0, k, (k % 16) == 0);
    end
    chk(pkt_count == 8'd255, "R7 count saturates at 255", pkt_count, 255);
    pop();
    chk(pkt_count == 8'd254, "R8 decrement from 255", pkt_count, 254);
    host_rdptr = 13'(radd(int'(wr_ptr), size - 1));
    run_frame(0, 32'h0, 1'b1, 0, 1'b1);
    chk(pkt_count == 8'd254, "R8 decrement with commit holds", pkt_count, 254);
    for (int k = 0; k < 254; k++) pop();
    chk(pkt_count == 0 && !pkt_pending, "R8 count and pending at zero", pkt_count, 0);
    pop();
    chk(pkt_count == 0, "R8 decrement at zero holds", pkt_count, 0);
    chk(rd_hits == 0 && out_ring == 0, "R6 R2 final write audit", rd_hits + out_ring, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule